// File: doc/BRIEF.md
# Packet transmit bus ingress with octet FIFO

This block sits on the physical-layer side of a 32-bit packet transmit bus. A packet-layer device presents one word per clock, qualified by an active-low write enable, together with start and end markers, a 2-bit modulo field that says how much of the final word is used, a per-packet error flag and one parity bit. The block checks parity on every enabled word and stores the word with its valid-octet count and packet tags in a word FIFO. An unpacker on the far side hands out one octet per transfer with start, end, abort and bad-checksum tags, ready for a framer.

Flow control toward the packet layer is a single packet-available output. It is high while the FIFO's free space, counted in octets as four per empty word slot, reaches a programmable threshold. It drops when space is short. The input bus has no ready signal. A word written while the FIFO is full is lost and is recorded in a sticky overflow bit. The output side is valid/ready. An octet moves only when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the octet and its tags stay unchanged. `out_valid` never drops without a transfer.

Top module: `pos_tx_ingress`

## Requirements
- R1: A word is sampled only on a clock edge where `in_wen_n` is 0. When `in_wen_n` is 1, data, markers, modulo, error and parity are ignored: nothing is stored and no parity error is raised.
- R2: Parity covers the 32 data bits plus `in_par`. With `cfg_par_even` = 0 (odd, the reset default) the total number of ones must be odd. With 1 it must be even.
- R3: A parity mismatch on an enabled word raises `par_err_pulse` for exactly the one cycle after the sampling edge. It sets `par_err_sticky`, which stays high until reset, and the word is still stored and delivered.
- R4: On an end word the modulo selects the valid octets: 00 = 4, 01 = 3, 10 = 2, 11 = 1. They are taken from the most significant byte downward, so bits 31:24 are delivered first.
- R5: A word without the end marker always delivers all four octets, whatever the modulo holds.
- R6: `out_sop` marks the first octet of every packet. A packet starts on the first enabled word after reset or after an end word, or on any word with `in_sop` = 1, so packets are delimited correctly even if `in_sop` is never driven.
- R7: `in_err` is honoured only on an end word. If `cfg_err_fcs` = 0, the last octet of that packet carries `out_abort`. If it is 1, that octet carries `out_badfcs`. `in_err` on any other word adds no tag.
- R8: `pkt_avail` is high exactly when (DEPTH − stored words) × 4 ≥ `cfg_avail_thresh`. It follows the fill level in the same cycle, so with a nonzero threshold it is low whenever the FIFO is full.
- R9: An enabled word arriving while all DEPTH word slots are occupied is dropped and sets `ovf_sticky`, which stays high until reset. The stored words are unaffected.
- R10: An octet transfers on a clock edge where `out_valid` and `out_ready` are both 1. While `out_valid` is 1 and `out_ready` is 0, `out_data` and all tags are held.
- R11: After reset the FIFO is empty, `out_valid` is 0, both sticky bits and the pulse are 0, and `pkt_avail` reflects an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_par_even | input | 1 | 0 = odd parity, 1 = even parity |
| cfg_err_fcs | input | 1 | Error flag action: 0 = abort tag, 1 = bad-checksum tag |
| cfg_avail_thresh | input | OCT_W (6) | Free-octet threshold for packet-available |
| in_wen_n | input | 1 | Write enable, active low |
| in_data | input | 32 | Data word, first octet in bits 31:24 |
| in_par | input | 1 | Parity bit over in_data |
| in_sop | input | 1 | Start-of-packet marker |
| in_eop | input | 1 | End-of-packet marker |
| in_mod | input | 2 | Unused-octet count on end words |
| in_err | input | 1 | Packet error request, end words only |
| pkt_avail | output | 1 | Enough free space for the threshold |
| par_err_pulse | output | 1 | One-cycle parity mismatch pulse |
| par_err_sticky | output | 1 | Parity mismatch seen since reset |
| ovf_sticky | output | 1 | Write dropped on full FIFO since reset |
| out_valid | output | 1 | Octet available |
| out_ready | input | 1 | Consumer accepts octet |
| out_data | output | 8 | Octet |
| out_sop | output | 1 | First octet of packet |
| out_eop | output | 1 | Last octet of packet |
| out_abort | output | 1 | Packet to be aborted (on last octet) |
| out_badfcs | output | 1 | Packet checksum to be corrupted (on last octet) |

## Verification
The hardest state to reach is a FIFO that is exactly full while one more enabled word arrives. The bench holds `out_ready` low and writes DEPTH words, checking `pkt_avail` after each. It then writes one extra word with a distinctive pattern and drains the FIFO, showing that the extra word never appears and the stored words are intact. A second hard case is a mid-packet word with the error flag and a nonzero modulo. That word must still yield four untagged octets, which the bench confirms before the true end word arrives.

// File: rtl/pos_tx_pkg.sv
package pos_tx_pkg;
  localparam int BUS_W   = 32;
  localparam int OCT_B   = 8;
  localparam int LANES   = BUS_W / OCT_B;
  localparam int LIDX_W  = $clog2(LANES);

  typedef struct packed {
    logic [BUS_W-1:0]  data;
    logic [LIDX_W-1:0] last_idx;
    logic              sop;
    logic              eop;
    logic              abort;
    logic              badfcs;
  } word_t;

  localparam int WORD_W = $bits(word_t);
endpackage

// File: rtl/pos_par_check.sv
module pos_par_check
  import pos_tx_pkg::*;
(
  input  logic             en,
  input  logic [BUS_W-1:0] data,
  input  logic             par,
  input  logic             even,
  output logic             mismatch
);
  logic ones_odd;
  assign ones_odd = ^{data, par};
  // odd sense wants ones_odd = 1, even sense wants 0
  assign mismatch = en & (ones_odd == even);
endmodule

// File: rtl/pos_word_pack.sv
module pos_word_pack
  import pos_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [BUS_W-1:0]  data,
  input  logic              sop,
  input  logic              eop,
  input  logic [LIDX_W-1:0] mod,
  input  logic              err,
  input  logic              cfg_err_fcs,
  output word_t             word
);
  logic expect_start;

  always_ff @(posedge clk) begin
    if (!rst_n)    expect_start <= 1'b1;
    else if (fire) expect_start <= eop;
  end

  always_comb begin
    word.data     = data;
    word.last_idx = eop ? (LIDX_W'(LANES - 1) - mod) : LIDX_W'(LANES - 1);
    word.sop      = sop | expect_start;
    word.eop      = eop;
    word.abort    = eop & err & ~cfg_err_fcs;
    word.badfcs   = eop & err & cfg_err_fcs;
  end
endmodule

// File: rtl/pos_word_fifo.sv
module pos_word_fifo #(
  parameter  int DEPTH = 8,
  parameter  int W     = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full,
  output logic [AW:0]  count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_wr, do_rd;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_wr   = wr_req & ~full;
  assign do_rd   = rd_en & ~empty;
  assign rd_data = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= nxt(wr_ptr);
      if (do_rd) rd_ptr <= nxt(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pos_octet_unpack.sv
module pos_octet_unpack
  import pos_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  word_t            head,
  input  logic             empty,
  input  logic             out_ready,
  output logic             pop,
  output logic             out_valid,
  output logic [OCT_B-1:0] out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic             out_abort,
  output logic             out_badfcs
);
  logic [LIDX_W-1:0] idx;
  logic [OCT_B-1:0]  lane [LANES];
  logic              last, fire;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = head.data[BUS_W-1-OCT_B*g -: OCT_B];
  end

  assign out_valid  = ~empty;
  assign out_data   = lane[idx];
  assign last       = (idx == head.last_idx);
  assign fire       = out_valid & out_ready;
  assign pop        = fire & last;
  assign out_sop    = out_valid & head.sop & (idx == '0);
  assign out_eop    = out_valid & head.eop & last;
  assign out_abort  = out_valid & head.abort & last;
  assign out_badfcs = out_valid & head.badfcs & last;

  always_ff @(posedge clk) begin
    if (!rst_n)    idx <= '0;
    else if (fire) idx <= last ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/pos_tx_ingress.sv
module pos_tx_ingress
  import pos_tx_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int OCT_W = $clog2(DEPTH * LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_par_even,
  input  logic              cfg_err_fcs,
  input  logic [OCT_W-1:0]  cfg_avail_thresh,
  input  logic              in_wen_n,
  input  logic [BUS_W-1:0]  in_data,
  input  logic              in_par,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [LIDX_W-1:0] in_mod,
  input  logic              in_err,
  output logic              pkt_avail,
  output logic              par_err_pulse,
  output logic              par_err_sticky,
  output logic              ovf_sticky,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OCT_B-1:0]  out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_abort,
  output logic              out_badfcs
);
  logic       fire, mismatch, full_w, empty_w, pop_w;
  logic [AW:0] count_w;
  word_t      wr_word, head_word;
  logic [OCT_W-1:0] free_oct;

  assign fire = ~in_wen_n;

  pos_par_check u_par (
    .en(fire), .data(in_data), .par(in_par), .even(cfg_par_even),
    .mismatch(mismatch)
  );

  pos_word_pack u_pack (
    .clk(clk), .rst_n(rst_n), .fire(fire), .data(in_data), .sop(in_sop),
    .eop(in_eop), .mod(in_mod), .err(in_err), .cfg_err_fcs(cfg_err_fcs),
    .word(wr_word)
  );

  pos_word_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_req(fire), .wr_data(wr_word),
    .rd_en(pop_w), .rd_data(head_word), .empty(empty_w), .full(full_w),
    .count(count_w)
  );

  pos_octet_unpack u_unpack (
    .clk(clk), .rst_n(rst_n), .head(head_word), .empty(empty_w),
    .out_ready(out_ready), .pop(pop_w), .out_valid(out_valid),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
    .out_abort(out_abort), .out_badfcs(out_badfcs)
  );

  assign free_oct  = OCT_W'((DEPTH - int'(count_w)) * LANES);
  assign pkt_avail = (free_oct >= cfg_avail_thresh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_err_pulse  <= 1'b0;
      par_err_sticky <= 1'b0;
      ovf_sticky     <= 1'b0;
    end else begin
      par_err_pulse <= mismatch;
      if (mismatch)       par_err_sticky <= 1'b1;
      if (fire && full_w) ovf_sticky     <= 1'b1;
    end
  end
endmodule

// File: rtl/pos_tx_ingress_chk.sv
module pos_tx_ingress_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int OCT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OCT_W-1:0] cfg_avail_thresh,
  input logic             in_wen_n,
  input logic             pkt_avail,
  input logic             par_err_pulse,
  input logic             par_err_sticky,
  input logic             ovf_sticky,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_sop,
  input logic             out_eop,
  input logic             out_abort,
  input logic             out_badfcs,
  input logic             fifo_full,
  input logic [AW:0]      fifo_count
);
  // R3: pulse always accompanied by sticky, and sticky never clears
  a_r3_pulse_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_pulse |-> par_err_sticky);
  a_r3_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_sticky |=> par_err_sticky);
  // R9: overflow sticky never clears; full FIFO never grows
  a_r9_ovf_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_sticky |=> ovf_sticky);
  a_r9_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= (AW+1)'(DEPTH));
  // R10: held octet under back-pressure
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_sop) && $stable(out_eop) && $stable(out_abort) &&
      $stable(out_badfcs)));
  // R7: error tags only on the last octet and never both
  a_r7_tag_on_eop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_abort || out_badfcs) |-> (out_eop && !(out_abort && out_badfcs)));
  // R8: with a nonzero threshold, available implies not full
  a_r8_avail_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_avail && cfg_avail_thresh != '0) |-> !fifo_full);
  // R1: an idle bus never grows the FIFO
  a_r1_idle_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    in_wen_n |=> (fifo_count <= $past(fifo_count)));
endmodule

bind pos_tx_ingress pos_tx_ingress_chk #(.DEPTH(DEPTH), .AW(AW), .OCT_W(OCT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_avail_thresh(cfg_avail_thresh),
  .in_wen_n(in_wen_n), .pkt_avail(pkt_avail), .par_err_pulse(par_err_pulse),
  .par_err_sticky(par_err_sticky), .ovf_sticky(ovf_sticky),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sop(out_sop), .out_eop(out_eop), .out_abort(out_abort),
  .out_badfcs(out_badfcs), .fifo_full(full_w), .fifo_count(count_w)
);

// File: tb/sim_pos_tx_ingress.sv
`timescale 1ns/1ps
module sim_pos_tx_ingress;
  logic clk = 0, rst_n = 0;
  logic cfg_par_even = 0, cfg_err_fcs = 0;
  logic [5:0] cfg_avail_thresh = 6'd8;
  logic in_wen_n = 1, in_par = 0, in_sop = 0, in_eop = 0, in_err = 0;
  logic [31:0] in_data = '0;
  logic [1:0] in_mod = '0;
  logic pkt_avail, par_err_pulse, par_err_sticky, ovf_sticky;
  logic out_valid, out_ready = 0, out_sop, out_eop, out_abort, out_badfcs;
  logic [7:0] out_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pos_tx_ingress u0 (
    .clk(clk), .rst_n(rst_n), .cfg_par_even(cfg_par_even),
    .cfg_err_fcs(cfg_err_fcs), .cfg_avail_thresh(cfg_avail_thresh),
    .in_wen_n(in_wen_n), .in_data(in_data), .in_par(in_par),
    .in_sop(in_sop), .in_eop(in_eop), .in_mod(in_mod), .in_err(in_err),
    .pkt_avail(pkt_avail), .par_err_pulse(par_err_pulse),
    .par_err_sticky(par_err_sticky), .ovf_sticky(ovf_sticky),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_abort(out_abort),
    .out_badfcs(out_badfcs)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic good_par(input logic [31:0] d, input logic even);
    return even ? ^d : ~^d;
  endfunction

  // drive one bus cycle; returns at the next falling edge with the bus idle
  task automatic wr(input logic [31:0] d, input logic sop, input logic eop,
                    input logic [1:0] m, input logic err, input logic bad_par,
                    input logic en = 1'b1);
    @(negedge clk);
    in_wen_n = ~en; in_data = d; in_sop = sop; in_eop = eop; in_mod = m;
    in_err = err; in_par = good_par(d, cfg_par_even) ^ bad_par;
    @(negedge clk);
    in_wen_n = 1; in_sop = 0; in_eop = 0; in_err = 0; in_mod = 0;
  endtask

  task automatic take(input logic [7:0] d, input logic sop, input logic eop,
                      input logic ab, input logic bf, input string req);
    @(negedge clk);
    chk(out_valid == 1, req, out_valid, 1);
    chk(out_data == d, req, out_data, d);
    chk({out_sop, out_eop, out_abort, out_badfcs} == {sop, eop, ab, bf}, req,
        {out_sop, out_eop, out_abort, out_badfcs}, {sop, eop, ab, bf});
    out_ready = 1;
    @(posedge clk); #1 out_ready = 0;
  endtask

  task automatic take_word(input logic [31:0] w, input int n, input logic sop,
                           input logic eop, input string req);
    for (int i = 0; i < n; i++)
      take(w[31-8*i -: 8], sop && i == 0, eop && i == n-1, 0, 0, req);
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk);
    chk(out_valid == 0, req, out_valid, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(out_valid == 0, "R11 valid", out_valid, 0);
    chk({par_err_pulse, par_err_sticky, ovf_sticky} == 3'b000, "R11 status",
        {par_err_pulse, par_err_sticky, ovf_sticky}, 0);
    chk(pkt_avail == 1, "R11 avail", pkt_avail, 1);
  endtask

  task automatic t_basic;
    wr(32'hA1B2C3D4, 1, 0, 2'd3, 0, 0);   // R5 modulo ignored mid-packet
    wr(32'h11223344, 0, 1, 2'd0, 0, 0);
    take_word(32'hA1B2C3D4, 4, 1, 0, "R5 full word");
    take_word(32'h11223344, 4, 0, 1, "R4 mod00");
    expect_empty("R4 end");
  endtask

  task automatic t_modulo;
    wr(32'h55667788, 0, 1, 2'd1, 0, 0);
    wr(32'h99AABBCC, 0, 1, 2'd2, 0, 0);
    wr(32'hDDEEFF01, 0, 1, 2'd3, 0, 0);
    take_word(32'h55667788, 3, 1, 1, "R4 mod01 R6");
    take_word(32'h99AABBCC, 2, 1, 1, "R4 mod10 R6");
    take_word(32'hDDEEFF01, 1, 1, 1, "R4 mod11 R6");
    expect_empty("R4 drained");
  endtask

  task automatic t_sop_marker;
    wr(32'h01020304, 0, 0, 0, 0, 0);
    wr(32'h05060708, 1, 1, 2'd2, 0, 0);    // R6 explicit marker mid-packet
    take_word(32'h01020304, 4, 1, 0, "R6 derived start");
    take_word(32'h05060708, 2, 1, 1, "R6 marker start");
  endtask

  task automatic t_err;
    cfg_err_fcs = 0;
    wr(32'hCAFEF00D, 0, 0, 2'd1, 1, 0);   // R7 flag ignored mid-packet
    wr(32'h0BADBEEF, 0, 1, 2'd2, 1, 0);
    take_word(32'hCAFEF00D, 4, 1, 0, "R7 ignored flag");
    take(8'h0B, 0, 0, 0, 0, "R7 abort");
    take(8'hAD, 0, 1, 1, 0, "R7 abort");
    cfg_err_fcs = 1;
    wr(32'h7E000000, 0, 1, 2'd3, 1, 0);
    take(8'h7E, 1, 1, 0, 1, "R7 badfcs");
    cfg_err_fcs = 0;
  endtask

  task automatic t_parity;
    wr(32'h00000007, 0, 1, 0, 0, 0);
    chk(par_err_pulse == 0, "R2 odd good", par_err_pulse, 0);
    chk(par_err_sticky == 0, "R2 odd good sticky", par_err_sticky, 0);
    take_word(32'h00000007, 4, 1, 1, "R2 word");
    wr(32'h12345678, 0, 1, 0, 0, 1);
    chk(par_err_pulse == 1, "R3 pulse", par_err_pulse, 1);
    chk(par_err_sticky == 1, "R3 sticky", par_err_sticky, 1);
    @(negedge clk);
    chk(par_err_pulse == 0, "R3 one cycle", par_err_pulse, 0);
    chk(par_err_sticky == 1, "R3 sticky holds", par_err_sticky, 1);
    take_word(32'h12345678, 4, 1, 1, "R3 word kept");
    cfg_par_even = 1;
    wr(32'h00000007, 0, 1, 0, 0, 0);
    chk(par_err_pulse == 0, "R2 even good", par_err_pulse, 0);
    take_word(32'h00000007, 4, 1, 1, "R2 even word");
    wr(32'h00000003, 0, 1, 0, 0, 1);
    chk(par_err_pulse == 1, "R2 even bad", par_err_pulse, 1);
    take_word(32'h00000003, 4, 1, 1, "R2 even bad word");
    cfg_par_even = 0;
  endtask

  task automatic t_disabled;
    wr(32'hFFFF0000, 1, 1, 0, 1, 1, 1'b0);
    chk(par_err_pulse == 0, "R1 no parity", par_err_pulse, 0);
    expect_empty("R1 not stored");
    chk(out_valid == 0, "R1 still empty", out_valid, 0);
  endtask

  task automatic t_backpressure;
    wr(32'hA5A5C3C3, 0, 1, 2'd2, 0, 0);
    repeat (3) @(negedge clk);
    chk(out_valid == 1 && out_data == 8'hA5, "R10 held", out_data, 8'hA5);
    take_word(32'hA5A5C3C3, 2, 1, 1, "R10 transfer");
  endtask

  task automatic t_fill;
    logic [31:0] w;
    for (int n = 1; n <= 8; n++) begin
      w = 32'h10203040 + n * 32'h01010101;
      wr(w, 0, n == 8, 0, 0, 0);
      chk(pkt_avail == ((8 - n) * 4 >= 8), "R8 avail", pkt_avail, (8 - n) * 4 >= 8);
    end
    chk(ovf_sticky == 0, "R9 before", ovf_sticky, 0);
    wr(32'hDEADBEEF, 0, 1, 0, 0, 0);
    chk(ovf_sticky == 1, "R9 overflow", ovf_sticky, 1);
    for (int n = 1; n <= 8; n++) begin
      w = 32'h10203040 + n * 32'h01010101;
      take_word(w, 4, n == 1, n == 8, "R9 intact");
    end
    expect_empty("R9 dropped word absent");
    chk(pkt_avail == 1, "R8 empty avail", pkt_avail, 1);
    cfg_avail_thresh = 6'd33;
    @(negedge clk);
    chk(pkt_avail == 0, "R8 threshold above size", pkt_avail, 0);
    cfg_avail_thresh = 6'd8;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_basic();
    t_modulo();
    t_sop_marker();
    t_err();
    t_parity();
    t_disabled();
    t_backpressure();
    t_fill();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule